// File: doc/BRIEF.md
# Fully-Associative Write-Through Word Cache

This block is a small cache placed between a processor and a slower main memory. Every line holds one word. A line's tag is the full word address, so any word may sit in any line. Each line has its own comparator. An incoming address is checked against all valid lines in the same cycle. A read that finds its word returns it in that same cycle and does not touch memory.

Every write goes straight through to main memory. Any miss, whether a read or a write, claims a line. The line chosen is the lowest-numbered empty line, or the line under a rotating pointer once all lines are full.

The processor holds `cpuReq`, `cpuAddr`, `cpuWe` and `cpuWdata` steady until it sees `cpuReady` high at a rising clock edge. That edge completes the access. On the memory side, `memReq` is held with a stable address, direction and write word until the memory answers with a one-cycle `memAck`. For a read, `memAck` comes with `memRdata`. Addresses count words, not bytes.

Top module: `assoc_wt_cache`

## Requirements
- R1: After reset every line is empty, `cpuReady` and `memReq` are low, and the first read of any address is handled as a miss.
- R2: A read whose address matches a valid line raises `cpuReady` in the same cycle as the request, with `cpuRdata` equal to that line's word, and raises no `memReq`.
- R3: A read miss raises `memReq` with `memWe`=0 and `memAddr` equal to the request address, starting in the cycle after the request and lasting up to and including the `memAck` cycle. `cpuReady` is high in the cycle after `memAck`, with `cpuRdata` equal to the fetched word. The line then holds that word, so a repeat read hits.
- R4: A write that hits updates that line's word, so a later read hit returns it. It also issues a memory write (`memWe`=1) of the same address and word.
- R5: A write that misses claims a line holding the new word and address, and also issues the memory write. A later read hit returns the written word, and after eviction a refetch returns it from memory.
- R6: A line is claimed at the lowest-numbered empty line while one exists.
- R7: Once every line is valid, the line claimed is the one under a pointer. The pointer is 0 after reset and advances by one, wrapping at the line count, on every claim.
- R8: While a memory access awaits `memAck`, `memReq` stays high and `cpuReady` stays low. With no request pending, `cpuReady` is low.
- R9: At most one line matches any address. A write to a cached address updates that line and never creates a second copy.
- R10: `memAddr`, `memWe` and `memWdata` stay unchanged through every cycle of one memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until completion |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWdata | input | DATA_W | Word to write |
| cpuRdata | output | DATA_W | Word read, valid when `cpuReady` is high on a read |
| cpuReady | output | 1 | Access completes at this edge |
| memReq | output | 1 | Memory access request, held until `memAck` |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Word written to memory |
| memRdata | input | DATA_W | Word returned by memory with `memAck` |
| memAck | input | 1 | One-cycle completion from memory |

## Verification
The bench drives reads and writes against a behavioural model of the lines and the pointer. Memory latency varies from access to access, and the bench checks ready timing, the memory signals and the returned word on every cycle.

It fills all lines and then forces evictions, so that pointer order decides which address is lost. A victim chosen out of order shows up as a hit where a miss was due, or the reverse.

It writes the same address twice and reads it back. A duplicated line would return stale or merged data. It also refetches evicted words that had been written. A lost write-through would return the memory's original word instead of the written one.

// File: rtl/assoc_wt_cache_pkg.sv
package assoc_wt_cache_pkg;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchReq;   // capture the request address and word
    logic writeLine;  // write at request time (hit update or miss claim)
    logic fillLine;   // claim a line with the word returned by memory
    logic selHeld;    // drive the held fill word on the read-data port
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDMEM = 2'd1,
    ST_WRMEM = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/assoc_wt_cache_dp.sv
module assoc_wt_cache_dp
  import assoc_wt_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic [ADDR_W-1:0] tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];
  logic [LINES-1:0]  validQ;
  logic [IDX_W-1:0]  rrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  logic [LINES-1:0]  hitVec;
  logic [IDX_W-1:0]  hitIdx;
  logic [DATA_W-1:0] hitData;
  logic              anyFree;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  victimIdx;
  logic              allocNow;
  logic [ADDR_W-1:0] allocTag;
  logic [DATA_W-1:0] allocData;

  // One comparator per line
  for (genvar g = 0; g < LINES; g++) begin : g_match
    assign hitVec[g] = validQ[g] && (tagQ[g] == cpuAddr);
  end

  assign hit = |hitVec;

  // OR-reduction encoder; valid because at most one line matches
  always_comb begin
    hitIdx  = '0;
    hitData = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hitVec[i]) begin
        hitIdx  = hitIdx | IDX_W'(i);
        hitData = hitData | dataQ[i];
      end
    end
  end

  // Lowest-numbered empty line wins, otherwise the rotating pointer
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign victimIdx = anyFree ? freeIdx : rrQ;
  assign allocNow  = (strobe.writeLine && !hit) || strobe.fillLine;
  assign allocTag  = strobe.fillLine ? addrQ : cpuAddr;
  assign allocData = strobe.fillLine ? memRdata : cpuWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      rrQ    <= '0;
    end else if (allocNow) begin
      validQ[victimIdx] <= 1'b1;
      rrQ <= (rrQ == LAST_IDX) ? '0 : rrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeLine && hit) begin
      dataQ[hitIdx] <= cpuWdata;
    end else if (allocNow) begin
      tagQ[victimIdx]  <= allocTag;
      dataQ[victimIdx] <= allocData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ  <= cpuAddr;
        wdataQ <= cpuWdata;
      end
      if (strobe.fillLine) begin
        rdataQ <= memRdata;
      end
    end
  end

  assign cpuRdata = strobe.selHeld ? rdataQ : hitData;
  assign memAddr  = addrQ;
  assign memWdata = wdataQ;

  // R9: never more than one matching line
  p_single_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

endmodule

// File: rtl/assoc_wt_cache_ctrl.sv
module assoc_wt_cache_ctrl
  import assoc_wt_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        cpuReady,
  output logic        memReq,
  output logic        memWe
);

  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          if (!cpuWe && hit) begin
            cpuReady = 1'b1;
          end else if (!cpuWe) begin
            strobe.latchReq = 1'b1;
            stateD          = ST_RDMEM;
          end else begin
            strobe.latchReq  = 1'b1;
            strobe.writeLine = 1'b1;
            stateD           = ST_WRMEM;
          end
        end
      end
      ST_RDMEM: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          stateD          = ST_DONE;
        end
      end
      ST_WRMEM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateD = ST_DONE;
      end
      ST_DONE: begin
        cpuReady       = 1'b1;
        strobe.selHeld = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R8: request held until acknowledged
  p_req_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R8: no completion while memory is outstanding
  p_no_ready_waiting_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  // R3 / R4: completion follows the acknowledge by one cycle
  p_ready_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> cpuReady);

endmodule

// File: rtl/assoc_wt_cache.sv
module assoc_wt_cache
  import assoc_wt_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  ctrlStrobe_t strobe;
  logic        hit;

  assoc_wt_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .hit      (hit),
    .memAck   (memAck),
    .strobe   (strobe),
    .cpuReady (cpuReady),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  assoc_wt_cache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .hit      (hit),
    .cpuRdata (cpuRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  // R10: memory-side fields steady during a request
  p_mem_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata) && $stable(memWe));

endmodule

// File: tb/assoc_wt_cache_tb_top.sv
module assoc_wt_cache_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cpuReq;
  logic [AW-1:0] cpuAddr;
  logic          cpuWe;
  logic [DW-1:0] cpuWdata;
  logic [DW-1:0] cpuRdata;
  logic          cpuReady;
  logic          memReq;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;
  logic          memAck;

  always #4 clk = ~clk;  // 125 MHz

  assoc_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [AW-1:0] mTag   [NL];
  bit            mValid [NL];
  logic [DW-1:0] mData  [NL];
  int            mPtr;
  logic [DW-1:0] memArr [int];
  int            waitCnt;
  int            curDelay;

  function automatic logic [DW-1:0] memRead(logic [AW-1:0] a);
    if (memArr.exists(int'(a))) return memArr[int'(a)];
    return (DW'(a) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // Advance one clock; the memory model reacts at the falling edge
  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
    if (memReq) begin
      if (waitCnt == curDelay) begin
        memAck = 1'b1;
        if (memWe) begin
          memArr[int'(memAddr)] = memWdata;
          memRdata = '0;
        end else begin
          memRdata = memRead(memAddr);
        end
        waitCnt = 0;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck  = 1'b0;
      waitCnt = 0;
    end
    #1;
  endtask

  task automatic idleCheck(string req);
    cpuReq = 1'b0;
    #1;
    chk(req, "idle cpuReady", DW'(cpuReady), '0);
    chk(req, "idle memReq", DW'(memReq), '0);
    nextCycle();
  endtask

  task automatic access(bit we, logic [AW-1:0] addr, logic [DW-1:0] wd, string req);
    int idx = -1;
    int lat;
    int vic;
    logic [DW-1:0] expRd = '0;
    for (int i = 0; i < NL; i++) if (mValid[i] && mTag[i] == addr) idx = i;
    if (!we && idx >= 0) begin
      lat   = 0;
      expRd = mData[idx];
    end else begin
      curDelay = int'(addr) % 3;
      lat      = curDelay + 2;
      if (!we) expRd = memRead(addr);
      if (we && idx >= 0) begin
        mData[idx] = wd;
      end else begin
        vic = -1;
        for (int i = NL - 1; i >= 0; i--) if (!mValid[i]) vic = i;
        if (vic < 0) vic = mPtr;
        mValid[vic] = 1;
        mTag[vic]   = addr;
        mData[vic]  = we ? wd : expRd;
        mPtr        = (mPtr + 1) % NL;
      end
    end
    cpuReq   = 1'b1;
    cpuAddr  = addr;
    cpuWe    = we;
    cpuWdata = wd;
    #1;
    for (int c = 0; c <= lat; c++) begin
      chk(req, "cpuReady", DW'(cpuReady), DW'(c == lat));
      chk(req, "memReq", DW'(memReq), DW'(lat > 0 && c >= 1 && c < lat));
      if (lat > 0 && c >= 1 && c < lat) begin
        chk(req, "memAddr", DW'(memAddr), DW'(addr));
        chk(req, "memWe", DW'(memWe), DW'(we));
        if (we) chk(req, "memWdata", memWdata, wd);
      end
      if (c == lat && !we) chk(req, "cpuRdata", cpuRdata, expRd);
      nextCycle();
    end
    cpuReq = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuAddr = '0; cpuWe = 1'b0; cpuWdata = '0;
    memAck = 1'b0; memRdata = '0; waitCnt = 0; curDelay = 0; mPtr = 0;
    for (int i = 0; i < NL; i++) begin mValid[i] = 0; mTag[i] = '0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: quiet outputs after reset
    chk("R1", "reset cpuReady", DW'(cpuReady), '0);
    chk("R1", "reset memReq", DW'(memReq), '0);
    nextCycle();
    idleCheck("R8");

    access(0, 16'h0010, '0, "R1");            // first read misses (R1, R3)
    access(0, 16'h0010, '0, "R2");            // read hit
    idleCheck("R2");
    access(1, 16'h0020, 32'hCAFE_0001, "R5"); // write miss claims line
    access(0, 16'h0020, '0, "R5");
    access(1, 16'h0010, 32'hBEEF_0002, "R4"); // write hit
    access(0, 16'h0010, '0, "R4");
    access(1, 16'h0010, 32'hBEEF_0003, "R9"); // same address again, no copy
    access(0, 16'h0010, '0, "R9");
    access(0, 16'h0020, '0, "R3");

    // R6: fill remaining empty lines in order
    for (int i = 0; i < 6; i++) access(0, AW'(16'h0030 + i), '0, "R6");
    access(0, 16'h0033, '0, "R6");

    // R7: all lines valid; pointer now at line 0
    access(0, 16'h0040, '0, "R7");   // evicts line 0 (0x10)
    access(0, 16'h0020, '0, "R7");   // line 1 still present
    access(0, 16'h0010, '0, "R7");   // refetch, written word from memory (R4), evicts 0x20
    access(0, 16'h0020, '0, "R5");   // refetch of written word after eviction
    access(0, 16'h0040, '0, "R7");
    idleCheck("R8");

    // R8 / R10: mixed traffic with varying memory latency
    for (int k = 0; k < 60; k++) begin
      access(k % 3 == 0, AW'(16'h0060 + (k * 7) % 13), DW'(32'h5A00_0000 + k), "R8");
      if (k % 5 == 0) idleCheck("R10");
    end
    idleCheck("R1");
    summary();
  end

endmodule